// File: doc/BRIEF.md
# Short Vector Register Sequencer

This block turns one floating-point arithmetic command into a run of register-address iterations for a short-vector coprocessor. The host presents a destination index, two source indices, an iteration-count field and a stride field. The block takes the command in a single handshake cycle. It then drives one iteration per cycle into the first multiply-accumulate execute stage. Each iteration carries destination and source register addresses and a valid strobe. After the last iteration the block raises a one-cycle done flag.

Register indices are split into a bank number and an offset within the bank. The bank of the destination selects the mode. A destination in bank 0 always gives a single scalar iteration. Any other bank gives a vector of `LEN+1` elements. Vector operands advance by `STRIDE+1` and wrap inside their own bank. A source that lies in bank 0 acts as a scalar and keeps its index for the whole run. The arithmetic, the register file and exception handling belong to other blocks.

Top module: `svec_seq`

## Requirements
- R1: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. From the next cycle `it_valid` is high and the first iteration shows the command's own indices.
- R2: When the destination bank (index bits 4:3) is not 0, the run has `cfg_len + 1` iterations. `it_valid` is high in consecutive cycles for the whole run.
- R3: When the destination bank is 0, the run has exactly one iteration, whatever the value of `cfg_len`.
- R4: From one iteration to the next, a vector operand's offset (index bits 2:0) grows by `cfg_stride + 1`, modulo 8.
- R5: A vector operand's bank bits never change during a run. The offset wraps within the bank and does not carry into the bank bits.
- R6: A source operand whose bank is 0 keeps the same index on every iteration of a run.
- R7: `busy` is high from the cycle after acceptance through the last iteration, and `cmd_ready` is its inverse. A `cmd_valid` raised while busy is ignored and leaves the running iteration stream unchanged.
- R8: `it_last` is high only on the final iteration. `done` is high for exactly one cycle, in the cycle right after the final iteration.
- R9: A synchronous reset drops `it_valid`, `busy` and `done` in the next cycle and raises `cmd_ready`. This also applies in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_dst | input | 5 | Destination register index (bank in bits 4:3) |
| cmd_src_a | input | 5 | First source register index |
| cmd_src_b | input | 5 | Second source register index |
| cfg_len | input | 3 | Iteration count minus one |
| cfg_stride | input | 2 | Register stride minus one |
| it_valid | output | 1 | Iteration strobe to the execute stage |
| it_dst | output | 5 | Destination index of this iteration |
| it_src_a | output | 5 | First source index of this iteration |
| it_src_b | output | 5 | Second source index of this iteration |
| it_last | output | 1 | This is the final iteration |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the final iteration |

## Verification
The main function is tried with the following command patterns, each of which isolates one rule:
- A four-element unit-stride vector with all operands in vector banks checks plain counting.
- A destination in bank 0 with a large `cfg_len` separates the scalar rule from the count field.
- Start offsets near the end of a bank combined with strides of 2, 3 and 4 show whether offsets wrap inside the bank or carry into the bank bits.
- Sources placed in bank 0 next to a vector destination tell held operands from stepping ones.
- A one-element vector shows that the first iteration is also the last.

Two further directed runs complete the coverage. One offers a second command during a run, which exposes any interference with the stream. The other resets in the middle of a run.

// File: rtl/svec_seq_pkg.sv
package svec_seq_pkg;
  typedef enum logic [1:0] {
    LANE_DST = 2'd0,
    LANE_SA  = 2'd1,
    LANE_SB  = 2'd2
  } lane_e;

  localparam int NUM_LANES = 3;
endpackage

// File: rtl/svec_seq_lane.sv
// One operand address generator: loads a start index, then steps the
// offset part within its bank unless the operand is held as a scalar.
module svec_seq_lane #(
  parameter int IDX_W  = 5,
  parameter int OFF_W  = 3,
  parameter int STEP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             adv,
  input  logic [IDX_W-1:0] load_idx,
  input  logic [STEP_W-1:0] load_step,
  input  logic             load_hold,
  output logic [IDX_W-1:0] idx_o
);
  localparam int SUM_W = (OFF_W > STEP_W ? OFF_W : STEP_W) + 1;

  logic [IDX_W-1:0]  idx_q;
  logic [STEP_W-1:0] step_q;
  logic              hold_q;
  logic [SUM_W-1:0]  off_sum;

  always_comb begin
    off_sum = SUM_W'(idx_q[OFF_W-1:0]) + SUM_W'(step_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      step_q <= '0;
      hold_q <= 1'b0;
    end else if (load) begin
      idx_q  <= load_idx;
      step_q <= load_step;
      hold_q <= load_hold;
    end else if (adv && !hold_q) begin
      // bank bits untouched: the offset wraps inside the bank
      idx_q[OFF_W-1:0] <= off_sum[OFF_W-1:0];
    end
  end

  assign idx_o = idx_q;

  // R5: bank part unchanged while a run advances
  p_bank_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> (idx_q[IDX_W-1:OFF_W] == $past(idx_q[IDX_W-1:OFF_W])));

  // R6: held scalar operand does not move
  p_scalar_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && hold_q) |=> $stable(idx_q));
endmodule

// File: rtl/svec_seq_ctl.sv
// Iteration counter: counts remaining elements, drives the strobe,
// the advance pulse for the lanes and the completion pulse.
module svec_seq_ctl #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_cnt,
  output logic             valid_o,
  output logic             last_o,
  output logic             adv_o,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             valid_q;
  logic             done_q;
  logic             last_w;
  logic             adv_w;

  assign last_w = valid_q && (cnt_q == '0);
  assign adv_w  = valid_q && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_w;
      if (load) begin
        valid_q <= 1'b1;
        cnt_q   <= load_cnt;
      end else if (last_w) begin
        valid_q <= 1'b0;
      end else if (adv_w) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign valid_o = valid_q;
  assign last_o  = last_w;
  assign adv_o   = adv_w;
  assign done_o  = done_q;

  // R1: acceptance produces an iteration in the next cycle
  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    load |=> valid_q);

  // R2: a run with iterations left keeps the strobe up
  p_no_gap_r2: assert property (@(posedge clk) disable iff (rst)
    adv_w |=> valid_q);

  // R7: the top never loads while a run is active
  p_no_load_busy_r7: assert property (@(posedge clk) disable iff (rst)
    load |-> !valid_q);

  // R8: completion follows the final iteration and lasts one cycle
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (rst)
    last_w |=> done_q);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: rtl/svec_seq.sv
module svec_seq
  import svec_seq_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int OFF_W = 3,
  parameter int LEN_W = 3,
  parameter int STR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [IDX_W-1:0] cmd_dst,
  input  logic [IDX_W-1:0] cmd_src_a,
  input  logic [IDX_W-1:0] cmd_src_b,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [STR_W-1:0] cfg_stride,
  output logic             it_valid,
  output logic [IDX_W-1:0] it_dst,
  output logic [IDX_W-1:0] it_src_a,
  output logic [IDX_W-1:0] it_src_b,
  output logic             it_last,
  output logic             busy,
  output logic             done
);
  localparam int STEP_W = STR_W + 1;
  localparam int BANK_W = IDX_W - OFF_W;

  logic              run_valid;
  logic              run_last;
  logic              run_adv;
  logic              run_done;
  logic              load;
  logic              dst_scalar;
  logic [LEN_W-1:0]  load_cnt;
  logic [STEP_W-1:0] load_step;

  logic [IDX_W-1:0] lane_in   [NUM_LANES];
  logic [IDX_W-1:0] lane_out  [NUM_LANES];
  logic             lane_hold [NUM_LANES];

  assign load       = cmd_valid && !run_valid;
  assign dst_scalar = (cmd_dst[IDX_W-1:OFF_W] == BANK_W'(0));
  assign load_cnt   = dst_scalar ? '0 : cfg_len;
  assign load_step  = STEP_W'(cfg_stride) + STEP_W'(1);

  assign lane_in[LANE_DST] = cmd_dst;
  assign lane_in[LANE_SA]  = cmd_src_a;
  assign lane_in[LANE_SB]  = cmd_src_b;

  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      if (g == int'(LANE_DST)) begin : g_dst
        assign lane_hold[g] = 1'b0;
      end else begin : g_src
        assign lane_hold[g] = (lane_in[g][IDX_W-1:OFF_W] == BANK_W'(0));
      end
      svec_seq_lane #(
        .IDX_W (IDX_W),
        .OFF_W (OFF_W),
        .STEP_W(STEP_W)
      ) u_lane (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .adv      (run_adv),
        .load_idx (lane_in[g]),
        .load_step(load_step),
        .load_hold(lane_hold[g]),
        .idx_o    (lane_out[g])
      );
    end
  endgenerate

  svec_seq_ctl #(
    .LEN_W(LEN_W)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_cnt(load_cnt),
    .valid_o (run_valid),
    .last_o  (run_last),
    .adv_o   (run_adv),
    .done_o  (run_done)
  );

  assign cmd_ready = !run_valid;
  assign busy      = run_valid;
  assign it_valid  = run_valid;
  assign it_last   = run_last;
  assign done      = run_done;
  assign it_dst    = lane_out[LANE_DST];
  assign it_src_a  = lane_out[LANE_SA];
  assign it_src_b  = lane_out[LANE_SB];

  // R3: a bank-0 destination gives a run of one iteration
  p_scalar_single_r3: assert property (@(posedge clk) disable iff (rst)
    (load && dst_scalar) |=> it_last);

  // R9: reset clears the strobe and completion
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!it_valid && !done));
endmodule

// File: tb/svec_seq_tb.sv
module svec_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [4:0] cmd_dst = '0, cmd_src_a = '0, cmd_src_b = '0;
  logic [2:0] cfg_len = '0;
  logic [1:0] cfg_stride = '0;
  logic       it_valid, it_last, busy, done;
  logic [4:0] it_dst, it_src_a, it_src_b;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  svec_seq u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dst(cmd_dst), .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b),
    .cfg_len(cfg_len), .cfg_stride(cfg_stride), .it_valid(it_valid),
    .it_dst(it_dst), .it_src_a(it_src_a), .it_src_b(it_src_b),
    .it_last(it_last), .busy(busy), .done(done)
  );

  // {dst, src_a, src_b, len, stride}
  localparam logic [19:0] VEC [8] = '{
    {5'd8,  5'd16, 5'd24, 3'd3, 2'd0},
    {5'd0,  5'd9,  5'd17, 3'd7, 2'd0},
    {5'd14, 5'd21, 5'd30, 3'd3, 2'd0},
    {5'd8,  5'd2,  5'd16, 3'd2, 2'd1},
    {5'd31, 5'd5,  5'd7,  3'd1, 2'd3},
    {5'd16, 5'd24, 5'd8,  3'd0, 2'd0},
    {5'd25, 5'd9,  5'd19, 3'd7, 2'd2},
    {5'd7,  5'd12, 5'd3,  3'd5, 2'd3}
  };

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] f_idx(logic [4:0] base, int k, int step, bit hold);
    int o;
    if (hold) return base;
    o = (int'(base[2:0]) + k * step) % 8;
    return {base[4:3], o[2:0]};
  endfunction

  // Issues a command and checks the whole stream; optionally offers an
  // intruding command during the run (R7).
  task automatic run_cmd(logic [19:0] v, bit intrude);
    logic [4:0] d, a, b;
    int len, step, n;
    bit ha, hb;
    {d, a, b} = v[19:5];
    len  = int'(v[4:2]);
    step = int'(v[1:0]) + 1;
    n    = (d[4:3] == 2'd0) ? 1 : len + 1;
    ha   = (a[4:3] == 2'd0);
    hb   = (b[4:3] == 2'd0);
    @(negedge clk);
    chk("R7", "ready before", int'(cmd_ready), 1);
    cmd_dst = d; cmd_src_a = a; cmd_src_b = b;
    cfg_len = v[4:2]; cfg_stride = v[1:0]; cmd_valid = 1'b1;
    @(negedge clk);
    if (intrude) begin
      cmd_dst = 5'd27; cmd_src_a = 5'd28; cmd_src_b = 5'd29;
      cfg_len = 3'd6; cfg_stride = 2'd2;
    end else begin
      cmd_valid = 1'b0;
    end
    for (int k = 0; k < n; k++) begin
      chk((k == 0) ? "R1" : "R2", "it_valid", int'(it_valid), 1);
      chk("R7", "busy", int'(busy), 1);
      chk("R7", "cmd_ready", int'(cmd_ready), 0);
      chk("R4 R5", "it_dst", int'(it_dst), int'(f_idx(d, k, step, 1'b0)));
      chk("R4 R5 R6", "it_src_a", int'(it_src_a), int'(f_idx(a, k, step, ha)));
      chk("R4 R5 R6", "it_src_b", int'(it_src_b), int'(f_idx(b, k, step, hb)));
      chk("R8", "it_last", int'(it_last), (k == n - 1) ? 1 : 0);
      chk("R8", "done during run", int'(done), 0);
      if (k == n - 1) cmd_valid = 1'b0;
      @(negedge clk);
    end
    chk((n == 1) ? "R3" : "R2", "it_valid after run", int'(it_valid), 0);
    chk("R8", "done", int'(done), 1);
    chk("R7", "busy after run", int'(busy), 0);
    @(negedge clk);
    chk("R8", "done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "reset it_valid", int'(it_valid), 0);
    chk("R9", "reset busy", int'(busy), 0);
    chk("R9", "reset done", int'(done), 0);
    chk("R9", "reset ready", int'(cmd_ready), 1);
    rst = 1'b0;

    for (int i = 0; i < 8; i++) run_cmd(VEC[i], 1'b0);

    // R7: command offered during a run must not disturb it
    run_cmd({5'd10, 5'd18, 5'd1, 3'd4, 2'd0}, 1'b1);

    // R9: reset in the middle of a long run
    @(negedge clk);
    cmd_dst = 5'd9; cmd_src_a = 5'd17; cmd_src_b = 5'd25;
    cfg_len = 3'd7; cfg_stride = 2'd0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R9", "running before reset", int'(it_valid), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9", "mid-run reset it_valid", int'(it_valid), 0);
    chk("R9", "mid-run reset busy", int'(busy), 0);
    chk("R9", "mid-run reset done", int'(done), 0);
    chk("R9", "mid-run reset ready", int'(cmd_ready), 1);

    // R1: a fresh command works right after reset
    run_cmd({5'd24, 5'd0, 5'd15, 3'd2, 2'd2}, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule